// File: doc/BRIEF.md
# Expansion Card Configuration Sequencer

This block is the card-side controller that lets host software find and program a plug-and-play expansion card. It holds the card's 8-bit select number and tracks four states: waiting for the unlock key, sleeping, taking part in isolation, and being configured. The bus decoder in front of it passes in one-cycle strobes: key detected, wake (with a data byte), select-number write, config-control write, bus reset, and a lost-isolation indication from the serial isolation logic.

Every card on the bus receives the same wake broadcast. A card compares the wake byte with its own select number. A byte of zero gathers every card that has not yet been numbered into isolation. A non-zero byte pulls exactly one card into configuration and parks all the others. The outputs tell the rest of the card which port accesses to honour, and they restart the serial identifier pointer when isolation begins again.

Top module: `cardCfgFsm`

## Requirements
- R1: While `busReset` is high at a clock edge, after that edge `csn` is 0x00 and `cfgState` is wait-for-key. This overrides every other strobe in the same cycle.
- R2: In wait-for-key (`cfgState`=0), wake, select-number write, config-control write and `isoLost` have no effect. `keySeen` moves the card to sleep (`cfgState`=1).
- R3: A wake with data 0x00, received by a card in sleep whose `csn` is 0x00, moves it to isolation (`cfgState`=2). `serialPtrRst` is high for exactly the one cycle that follows.
- R4: A wake with data 0x00, received by a card in isolation whose `csn` is 0x00, keeps it in isolation and pulses `serialPtrRst` again.
- R5: A wake whose non-zero data equals `csn` moves a card in sleep, isolation or config to config (`cfgState`=3).
- R6: A wake whose data differs from `csn` moves a card to sleep. This includes a card in config that receives a wake with data 0x00.
- R7: A select-number write in isolation loads `csnWrData` into `csn` and moves the card to config. In sleep the same write is ignored.
- R8: `isoLost` in isolation returns the card to sleep and keeps `csn`.
- R9: A config-control write with bit 1 set and bit 2 clear returns the card to wait-for-key and keeps `csn`.
- R10: A config-control write with bit 2 set clears `csn` without changing the state. With bits 2:0 = 111 the result equals a bus reset: `csn` is 0x00 and the state is wait-for-key.
- R11: `portEnable` is high whenever the state is not wait-for-key. `isoActive` is high only in isolation. `cfgActive` is high only in config.
- R12: A config-control write takes precedence over a wake strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| busReset | input | 1 | Synchronous bus reset event |
| keySeen | input | 1 | Unlock key detected strobe |
| wakeStb | input | 1 | Wake command strobe |
| wakeData | input | 8 | Wake command data byte |
| csnWrStb | input | 1 | Select-number write strobe |
| csnWrData | input | 8 | Select-number write data |
| ctrlWrStb | input | 1 | Config-control write strobe |
| ctrlWrData | input | 3 | Config-control write data, bits 2:0 |
| isoLost | input | 1 | This card lost serial isolation |
| cfgState | output | 2 | 0 wait-for-key, 1 sleep, 2 isolation, 3 config |
| csn | output | 8 | Current select number |
| serialPtrRst | output | 1 | One-cycle restart of the serial identifier pointer |
| portEnable | output | 1 | Configuration port accesses honoured |
| isoActive | output | 1 | Isolation reads honoured |
| cfgActive | output | 1 | Configuration register access honoured |

## Verification
On every cycle, the assertions check the single-card transitions: reset, key handling, the wake match and mismatch cases, entry into isolation together with its pointer pulse, the select-number load, lost isolation, and both config-control returns. Only the bench scenarios can show the broadcast behaviour. Two cards share every command strobe: they must separate through `isoLost`, pick up distinct numbers one after the other, and respond selectively to non-zero wakes. A soft return must keep both numbers. The bench also covers the strobes that are ignored in sleep and wait-for-key, and same-cycle command priority.

// File: rtl/cardCfgPkg.sv
package cardCfgPkg;

  localparam int CTRL_W = 3;

  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } cfgState_e;

  // strobes from control to the select-number datapath
  typedef struct packed {
    logic csnLoad;
    logic csnClear;
    logic ptrRst;
  } dpStrobe_t;

endpackage

// File: rtl/cardCfgCtrl.sv
module cardCfgCtrl
  import cardCfgPkg::*;
#(
  parameter int CSN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              keySeen,
  input  logic              wakeStb,
  input  logic [CSN_W-1:0]  wakeData,
  input  logic              csnWrStb,
  input  logic              ctrlWrStb,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              isoLost,
  input  logic [CSN_W-1:0]  csnCur,
  output cfgState_e         stateQ,
  output dpStrobe_t         dpStb
);

  cfgState_e stateNxt;
  logic      wakeMatch;
  logic      wakeZero;

  assign wakeMatch = (wakeData == csnCur);
  assign wakeZero  = (wakeData == '0);

  always_comb begin
    stateNxt = stateQ;
    dpStb    = '0;
    if (busReset) begin
      stateNxt       = ST_WAIT_KEY;
      dpStb.csnClear = 1'b1;
    end else if (stateQ == ST_WAIT_KEY) begin
      if (keySeen) stateNxt = ST_SLEEP;
    end else if (ctrlWrStb) begin
      if (ctrlWrData[2]) dpStb.csnClear = 1'b1;
      if (ctrlWrData[1]) stateNxt = ST_WAIT_KEY;
    end else if (wakeStb) begin
      if (wakeMatch && wakeZero) begin
        stateNxt     = ST_ISOLATE;
        dpStb.ptrRst = 1'b1;
      end else if (wakeMatch) begin
        stateNxt = ST_CONFIG;
      end else begin
        stateNxt = ST_SLEEP;
      end
    end else if (csnWrStb && (stateQ == ST_ISOLATE || stateQ == ST_CONFIG)) begin
      dpStb.csnLoad = 1'b1;
      stateNxt      = ST_CONFIG;
    end else if (isoLost && stateQ == ST_ISOLATE) begin
      stateNxt = ST_SLEEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_WAIT_KEY;
    else       stateQ <= stateNxt;
  end

  AST_BUS_RESET_KEYWAIT: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> stateQ == ST_WAIT_KEY) else $error("bus reset state"); // R1
  AST_KEYWAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT_KEY && !keySeen && !busReset) |=> stateQ == ST_WAIT_KEY)
    else $error("left key wait"); // R2
  AST_KEY_TO_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT_KEY && keySeen && !busReset) |=> stateQ == ST_SLEEP)
    else $error("key not taken"); // R2
  AST_ISO_LOST_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ISOLATE && isoLost && !busReset && !ctrlWrStb && !wakeStb && !csnWrStb)
    |=> stateQ == ST_SLEEP) else $error("isolation loss"); // R8

endmodule

// File: rtl/cardCsnPath.sv
module cardCsnPath
  import cardCfgPkg::*;
#(
  parameter int CSN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        dpStb,
  input  logic [CSN_W-1:0] csnWrData,
  output logic [CSN_W-1:0] csnQ,
  output logic             ptrRstQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csnQ    <= '0;
      ptrRstQ <= 1'b0;
    end else begin
      ptrRstQ <= dpStb.ptrRst;
      if (dpStb.csnClear)     csnQ <= '0;
      else if (dpStb.csnLoad) csnQ <= csnWrData;
    end
  end

endmodule

// File: rtl/cardCfgFsm.sv
module cardCfgFsm
  import cardCfgPkg::*;
#(
  parameter int CSN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              keySeen,
  input  logic              wakeStb,
  input  logic [CSN_W-1:0]  wakeData,
  input  logic              csnWrStb,
  input  logic [CSN_W-1:0]  csnWrData,
  input  logic              ctrlWrStb,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              isoLost,
  output logic [1:0]        cfgState,
  output logic [CSN_W-1:0]  csn,
  output logic              serialPtrRst,
  output logic              portEnable,
  output logic              isoActive,
  output logic              cfgActive
);

  cfgState_e        stateQ;
  dpStrobe_t        dpStb;
  logic [CSN_W-1:0] csnQ;
  logic             ptrRstQ;

  cardCfgCtrl #(.CSN_W(CSN_W)) ctrlU (
    .clk(clk), .rstN(rstN), .busReset(busReset), .keySeen(keySeen),
    .wakeStb(wakeStb), .wakeData(wakeData), .csnWrStb(csnWrStb),
    .ctrlWrStb(ctrlWrStb), .ctrlWrData(ctrlWrData), .isoLost(isoLost),
    .csnCur(csnQ), .stateQ(stateQ), .dpStb(dpStb)
  );

  cardCsnPath #(.CSN_W(CSN_W)) pathU (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .csnWrData(csnWrData),
    .csnQ(csnQ), .ptrRstQ(ptrRstQ)
  );

  assign cfgState     = stateQ;
  assign csn          = csnQ;
  assign serialPtrRst = ptrRstQ;
  assign portEnable   = (stateQ != ST_WAIT_KEY);
  assign isoActive    = (stateQ == ST_ISOLATE);
  assign cfgActive    = (stateQ == ST_CONFIG);

  AST_BUS_RESET_CSN: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> csn == '0) else $error("bus reset csn"); // R1
  AST_ISO_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (cfgState == 2'd1 && wakeStb && wakeData == '0 && csn == '0 && !busReset && !ctrlWrStb)
    |=> (cfgState == 2'd2 && serialPtrRst)) else $error("iso entry"); // R3
  AST_ISO_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    (cfgState == 2'd2 && wakeStb && wakeData == '0 && csn == '0 && !busReset && !ctrlWrStb)
    |=> (cfgState == 2'd2 && serialPtrRst)) else $error("iso retry"); // R4
  AST_WAKE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (portEnable && wakeStb && wakeData != '0 && wakeData == csn && !busReset && !ctrlWrStb)
    |=> cfgState == 2'd3) else $error("wake match"); // R5
  AST_WAKE_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (portEnable && wakeStb && wakeData != csn && !busReset && !ctrlWrStb)
    |=> cfgState == 2'd1) else $error("wake miss"); // R6
  AST_CSN_ASSIGN: assert property (@(posedge clk) disable iff (!rstN)
    (cfgState == 2'd2 && csnWrStb && !wakeStb && !ctrlWrStb && !busReset)
    |=> (cfgState == 2'd3 && csn == $past(csnWrData))) else $error("csn assign"); // R7
  AST_SOFT_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (portEnable && ctrlWrStb && ctrlWrData[2:1] == 2'b01 && !busReset)
    |=> (cfgState == 2'd0 && $stable(csn))) else $error("soft return"); // R9
  AST_FULL_CTRL_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (portEnable && ctrlWrStb && ctrlWrData == 3'b111)
    |=> (cfgState == 2'd0 && csn == '0)) else $error("ctrl full reset"); // R10
  AST_ENABLE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isoActive, cfgActive}) && ((isoActive || cfgActive) -> portEnable))
    else $error("enables"); // R11

endmodule

// File: tb/cardCfgFsm_test.sv
`timescale 1ns/1ps
module cardCfgFsm_test;

  typedef struct {
    string      tag;
    int         card;
    int         due;
    logic [1:0] st;
    logic [7:0] csn;
    logic       ptr;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0, keySeen = 1'b0, wakeStb = 1'b0, csnWrStb = 1'b0, ctrlWrStb = 1'b0;
  logic [7:0] wakeData = '0, csnWrData = '0;
  logic [2:0] ctrlWrData = '0;
  logic isoLostA = 1'b0, isoLostB = 1'b0;

  logic [1:0] stA, stB;
  logic [7:0] csnA, csnB;
  logic ptrA, ptrB, peA, peB, iaA, iaB, caA, caB;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  expItem_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cardCfgFsm uut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .keySeen(keySeen),
    .wakeStb(wakeStb), .wakeData(wakeData), .csnWrStb(csnWrStb), .csnWrData(csnWrData),
    .ctrlWrStb(ctrlWrStb), .ctrlWrData(ctrlWrData), .isoLost(isoLostA),
    .cfgState(stA), .csn(csnA), .serialPtrRst(ptrA),
    .portEnable(peA), .isoActive(iaA), .cfgActive(caA)
  );

  cardCfgFsm card2 (
    .clk(clk), .rstN(rstN), .busReset(busReset), .keySeen(keySeen),
    .wakeStb(wakeStb), .wakeData(wakeData), .csnWrStb(csnWrStb), .csnWrData(csnWrData),
    .ctrlWrStb(ctrlWrStb), .ctrlWrData(ctrlWrData), .isoLost(isoLostB),
    .cfgState(stB), .csn(csnB), .serialPtrRst(ptrB),
    .portEnable(peB), .isoActive(iaB), .cfgActive(caB)
  );

  task automatic pushBoth(string tag, logic [1:0] sa, logic [7:0] ca, logic pa,
                          logic [1:0] sb, logic [7:0] cb, logic pb);
    expItem_t it;
    it.tag = tag; it.due = cyc + 1;
    it.card = 0; it.st = sa; it.csn = ca; it.ptr = pa; q.push_back(it);
    it.card = 1; it.st = sb; it.csn = cb; it.ptr = pb; q.push_back(it);
  endtask

  task automatic clearIns();
    busReset = 0; keySeen = 0; wakeStb = 0; csnWrStb = 0; ctrlWrStb = 0;
    isoLostA = 0; isoLostB = 0;
  endtask

  task automatic finishStep();
    @(negedge clk);
    clearIns();
  endtask

  // monitor: compare expected items as the cards produce them
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      expItem_t it;
      logic [1:0] s; logic [7:0] c; logic p, pe, ia, ca;
      it = q.pop_front();
      if (it.card == 0) begin s = stA; c = csnA; p = ptrA; pe = peA; ia = iaA; ca = caA; end
      else              begin s = stB; c = csnB; p = ptrB; pe = peB; ia = iaB; ca = caB; end
      checks++;
      if (s !== it.st || c !== it.csn || p !== it.ptr) begin
        fails++;
        $display("FAIL %s card%0d: state=%0d csn=%02h ptr=%0b expected state=%0d csn=%02h ptr=%0b",
                 it.tag, it.card, s, c, p, it.st, it.csn, it.ptr);
      end
      checks++;
      if (pe !== (it.st != 2'd0) || ia !== (it.st == 2'd2) || ca !== (it.st == 2'd3)) begin
        fails++;
        $display("FAIL R11 card%0d: enables pe=%0b iso=%0b cfg=%0b expected for state %0d",
                 it.card, pe, ia, ca, it.st);
      end
    end
  end

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pushBoth("R1 reset state", 0, 8'h00, 0, 0, 8'h00, 0); finishStep();

    // R2: ignored in wait-for-key
    @(negedge clk); wakeStb = 1; wakeData = 8'h00;
    pushBoth("R2 wake ignored", 0, 8'h00, 0, 0, 8'h00, 0); finishStep();
    @(negedge clk); csnWrStb = 1; csnWrData = 8'h55; ctrlWrStb = 1; ctrlWrData = 3'b100;
    pushBoth("R2 writes ignored", 0, 8'h00, 0, 0, 8'h00, 0); finishStep();
    @(negedge clk); keySeen = 1;
    pushBoth("R2 key to sleep", 1, 8'h00, 0, 1, 8'h00, 0); finishStep();

    // R7: csn write ignored in sleep
    @(negedge clk); csnWrStb = 1; csnWrData = 8'h33;
    pushBoth("R7 csn write in sleep", 1, 8'h00, 0, 1, 8'h00, 0); finishStep();

    // R3: isolation entry and pulse length
    @(negedge clk); wakeStb = 1; wakeData = 8'h00;
    pushBoth("R3 enter isolation", 2, 8'h00, 1, 2, 8'h00, 1); finishStep();
    @(negedge clk);
    pushBoth("R3 pointer pulse ends", 2, 8'h00, 0, 2, 8'h00, 0); finishStep();

    // R4: retry in isolation
    @(negedge clk); wakeStb = 1; wakeData = 8'h00;
    pushBoth("R4 isolation retry", 2, 8'h00, 1, 2, 8'h00, 1); finishStep();

    // R8: second card loses isolation
    @(negedge clk); isoLostB = 1;
    pushBoth("R8 isolation lost", 2, 8'h00, 0, 1, 8'h00, 0); finishStep();

    // R7: first card numbered
    @(negedge clk); csnWrStb = 1; csnWrData = 8'h01;
    pushBoth("R7 assign csn 1", 3, 8'h01, 0, 1, 8'h00, 0); finishStep();

    // R6 / R3: wake zero parks numbered card, isolates the other
    @(negedge clk); wakeStb = 1; wakeData = 8'h00;
    pushBoth("R6 config to sleep, R3 second isolates", 1, 8'h01, 0, 2, 8'h00, 1); finishStep();
    @(negedge clk); csnWrStb = 1; csnWrData = 8'h02;
    pushBoth("R7 assign csn 2", 1, 8'h01, 0, 3, 8'h02, 0); finishStep();

    // R5 / R6: selective wake
    @(negedge clk); wakeStb = 1; wakeData = 8'h01;
    pushBoth("R5 select card 1", 3, 8'h01, 0, 1, 8'h02, 0); finishStep();
    @(negedge clk); wakeStb = 1; wakeData = 8'h02;
    pushBoth("R5 select card 2", 1, 8'h01, 0, 3, 8'h02, 0); finishStep();

    // R9: soft return keeps both numbers
    @(negedge clk); ctrlWrStb = 1; ctrlWrData = 3'b010;
    pushBoth("R9 soft return", 0, 8'h01, 0, 0, 8'h02, 0); finishStep();

    // R10: bit 2 alone clears csn, state unchanged
    @(negedge clk); keySeen = 1;
    pushBoth("R2 key again", 1, 8'h01, 0, 1, 8'h02, 0); finishStep();
    @(negedge clk); ctrlWrStb = 1; ctrlWrData = 3'b100;
    pushBoth("R10 csn clear only", 1, 8'h00, 0, 1, 8'h00, 0); finishStep();
    @(negedge clk); wakeStb = 1; wakeData = 8'h00;
    pushBoth("R3 re-isolate", 2, 8'h00, 1, 2, 8'h00, 1); finishStep();
    @(negedge clk); csnWrStb = 1; csnWrData = 8'h05;
    pushBoth("R7 both assigned 5", 3, 8'h05, 0, 3, 8'h05, 0); finishStep();
    @(negedge clk); ctrlWrStb = 1; ctrlWrData = 3'b111;
    pushBoth("R10 full control reset", 0, 8'h00, 0, 0, 8'h00, 0); finishStep();

    // R1: bus reset from config
    @(negedge clk); keySeen = 1;
    pushBoth("R2 key", 1, 8'h00, 0, 1, 8'h00, 0); finishStep();
    @(negedge clk); wakeStb = 1; wakeData = 8'h00;
    pushBoth("R3 isolate", 2, 8'h00, 1, 2, 8'h00, 1); finishStep();
    @(negedge clk); csnWrStb = 1; csnWrData = 8'h09;
    pushBoth("R7 assign 9", 3, 8'h09, 0, 3, 8'h09, 0); finishStep();
    @(negedge clk); busReset = 1; wakeStb = 1; wakeData = 8'h09;
    pushBoth("R1 bus reset wins", 0, 8'h00, 0, 0, 8'h00, 0); finishStep();

    // R12: control write beats wake in the same cycle
    @(negedge clk); keySeen = 1;
    pushBoth("R2 key", 1, 8'h00, 0, 1, 8'h00, 0); finishStep();
    @(negedge clk); ctrlWrStb = 1; ctrlWrData = 3'b010; wakeStb = 1; wakeData = 8'h00;
    pushBoth("R12 control over wake", 0, 8'h00, 0, 0, 8'h00, 0); finishStep();

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule